// File: doc/BRIEF.md
# Two-Level Function-Indexed Translation Walker

This block converts a local-memory offset issued on behalf of a virtual function into a host local-memory offset. It walks a two-level table held in memory. The first level is a directory with one 32-bit entry per function ID. Its base comes from the `root_base` control input. A valid directory entry points to a per-function leaf table aligned to 64 KB. The leaf entry selected by the guest offset names a 2 MB host page. The walker returns either the translated host offset or a fault with a cause code. Requests whose function ID or offset cannot be translated are refused before any memory access.

Requests and responses use valid/ready handshakes. A request is taken on a cycle where both `req_valid` and `req_ready` are high, and `req_ready` is high only while the walker is idle. A response is presented with `resp_valid` and stays unchanged until the cycle on which `resp_ready` is high. Memory reads go through a single-outstanding port. The walker holds the address steady until `mem_req_ready` accepts it. It then raises `mem_rsp_ready` and waits for `mem_rsp_valid` with the entry word. `root_base` is a plain control input and must stay constant while a walk is in progress.

The default host and guest width is 37 bits, which gives 65536 leaf entries per function. A width of 35 bits gives 16384 leaf entries.

Top module: `mtt_walker`

## Requirements
- R1: Out of reset, `req_ready` is 1, `resp_valid` is 0 and `mem_req_valid` is 0.
- R2: The first read of a walk uses address `root_base + function_id * 4`.
- R3: A request with function ID 0, a function ID of 64 or more, or any offset bit set at position HAW or above gets a fault response with cause 1. No memory read is issued for it.
- R4: If bit 0 (valid) of the directory entry is 0, the response is a fault with cause 2, after exactly one memory read.
- R5: The second read uses address `(directory entry bits HAW-13..4) * 65536 + (offset bits HAW-1..21) * 4`.
- R6: If bit 0 (valid) of the leaf entry is 0, the response is a fault with cause 3, after exactly two memory reads.
- R7: On success, `resp_fault` is 0, `resp_cause` is 0 and `resp_hofs` = `(leaf entry bits HAW-17..5) * 2 MB` OR `offset bits 20..0`. A fault response carries `resp_hofs` = 0.
- R8: Only one walk is in flight at a time. `req_ready` is low from the cycle after a request is accepted until the response has been taken.
- R9: While `resp_valid` is high and `resp_ready` is low, `resp_valid`, `resp_fault`, `resp_cause` and `resp_hofs` keep their values.
- R10: A memory request keeps `mem_req_valid` high and `mem_req_addr` unchanged until `mem_req_ready` is high. No new memory request is raised while a read response is awaited.
- R11: Reserved bits of directory entries (3..1 and above HAW-13) and of leaf entries (4..1 and above HAW-17) do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| root_base | input | HAW | Byte address of the directory |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and accepting a request |
| req_fn | input | FN_W | Function ID of the request |
| req_ofs | input | OFS_W | Guest local-memory offset |
| resp_valid | output | 1 | Response present |
| resp_ready | input | 1 | Requester takes the response |
| resp_fault | output | 1 | Translation failed |
| resp_cause | output | 2 | 0 ok, 1 bad request, 2 directory invalid, 3 leaf invalid |
| resp_hofs | output | HAW | Translated host offset (0 on fault) |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | HAW | Byte address of the 32-bit entry to read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_ready | output | 1 | Walker waiting for read data |
| mem_rsp_data | input | 32 | Entry word returned by memory |

## Verification
The assertions assume the memory side follows the handshake. It returns one `mem_rsp_valid` beat per accepted read, and only while `mem_rsp_ready` is high. They also assume `root_base` does not move during a walk. The bench memory model responds only after it has accepted a request, with a random 0 to 2 cycle delay, and drops valid right after the beat is taken. `root_base` is fixed for the whole run. Requests, `mem_req_ready` stalls and response back-pressure are all driven at falling edges. That keeps every handshake legal while still stalling each channel at random.

// File: rtl/walk_pkg.sv
package walk_pkg;

  localparam int ENT_W       = 32;
  localparam int PAGE_SHIFT  = 21;
  localparam int TBL_SHIFT   = 16;
  localparam int DIR_PTR_LSB = 4;
  localparam int LEAF_PG_LSB = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_DIR,
    ST_WT_DIR,
    ST_RD_LEAF,
    ST_WT_LEAF,
    ST_RESP
  } walk_st_e;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_RANGE = 2'd1,
    CAUSE_DIR   = 2'd2,
    CAUSE_LEAF  = 2'd3
  } walk_cause_e;

endpackage

// File: rtl/walk_reqcheck.sv
module walk_reqcheck #(
  parameter int HAW    = 37,
  parameter int OFS_W  = 48,
  parameter int FN_W   = 8,
  parameter int NUM_FN = 64
) (
  input  logic [FN_W-1:0]  fn,
  input  logic [OFS_W-1:0] ofs,
  output logic             bad
);

  logic fn_bad;
  logic ofs_bad;

  assign fn_bad = (fn == '0) || (32'(fn) >= NUM_FN);

  generate
    if (OFS_W > HAW) begin : g_wide
      assign ofs_bad = |ofs[OFS_W-1:HAW];
    end else begin : g_narrow
      assign ofs_bad = 1'b0;
    end
  endgenerate

  assign bad = fn_bad || ofs_bad;

endmodule

// File: rtl/walk_addrgen.sv
module walk_addrgen
  import walk_pkg::*;
#(
  parameter int HAW  = 37,
  parameter int FN_W = 8,
  localparam int PTR_W = HAW - TBL_SHIFT,
  localparam int PG_W  = HAW - PAGE_SHIFT
) (
  input  logic [HAW-1:0]   root,
  input  logic [FN_W-1:0]  fn,
  input  logic [HAW-1:0]   ofs,
  input  logic [PTR_W-1:0] ptr,
  input  logic [ENT_W-1:0] ent,
  output logic [HAW-1:0]   dir_addr,
  output logic [HAW-1:0]   leaf_addr,
  output logic             ent_valid,
  output logic [PTR_W-1:0] ent_ptr,
  output logic [HAW-1:0]   ent_host
);

  logic [PG_W-1:0] idx;
  logic [PG_W-1:0] page;

  assign idx       = ofs[HAW-1:PAGE_SHIFT];
  assign dir_addr  = root + (HAW'(fn) << 2);
  assign leaf_addr = {ptr, {TBL_SHIFT{1'b0}}} + (HAW'(idx) << 2);

  assign ent_valid = ent[0];
  assign ent_ptr   = ent[DIR_PTR_LSB +: PTR_W];
  assign page      = ent[LEAF_PG_LSB +: PG_W];
  assign ent_host  = {page, ofs[PAGE_SHIFT-1:0]};

endmodule

// File: rtl/walk_fsm.sv
module walk_fsm
  import walk_pkg::*;
#(
  parameter int HAW   = 37,
  parameter int OFS_W = 48,
  parameter int FN_W  = 8,
  localparam int PTR_W = HAW - TBL_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [FN_W-1:0]  req_fn,
  input  logic [OFS_W-1:0] req_ofs,
  input  logic             req_bad,
  output logic             req_ready,
  input  logic             mem_req_ready,
  input  logic             mem_rsp_valid,
  output logic             mem_req_valid,
  output logic             mem_rsp_ready,
  output logic             sel_leaf,
  input  logic             ent_valid,
  input  logic [PTR_W-1:0] ent_ptr,
  input  logic [HAW-1:0]   ent_host,
  output logic [FN_W-1:0]  fn_q,
  output logic [HAW-1:0]   ofs_q,
  output logic [PTR_W-1:0] ptr_q,
  input  logic             resp_ready,
  output logic             resp_valid,
  output logic             resp_fault,
  output logic [1:0]       resp_cause,
  output logic [HAW-1:0]   resp_hofs
);

  walk_st_e    st_q;
  walk_cause_e cause_q;
  logic        fault_q;
  logic [HAW-1:0] host_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      fn_q    <= '0;
      ofs_q   <= '0;
      ptr_q   <= '0;
      fault_q <= 1'b0;
      cause_q <= CAUSE_NONE;
      host_q  <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (req_valid) begin
            fn_q  <= req_fn;
            ofs_q <= req_ofs[HAW-1:0];
            if (req_bad) begin
              fault_q <= 1'b1;
              cause_q <= CAUSE_RANGE;
              host_q  <= '0;
              st_q    <= ST_RESP;
            end else begin
              st_q <= ST_RD_DIR;
            end
          end
        end
        ST_RD_DIR: if (mem_req_ready) st_q <= ST_WT_DIR;
        ST_WT_DIR: begin
          if (mem_rsp_valid) begin
            if (!ent_valid) begin
              fault_q <= 1'b1;
              cause_q <= CAUSE_DIR;
              host_q  <= '0;
              st_q    <= ST_RESP;
            end else begin
              ptr_q <= ent_ptr;
              st_q  <= ST_RD_LEAF;
            end
          end
        end
        ST_RD_LEAF: if (mem_req_ready) st_q <= ST_WT_LEAF;
        ST_WT_LEAF: begin
          if (mem_rsp_valid) begin
            if (!ent_valid) begin
              fault_q <= 1'b1;
              cause_q <= CAUSE_LEAF;
              host_q  <= '0;
            end else begin
              fault_q <= 1'b0;
              cause_q <= CAUSE_NONE;
              host_q  <= ent_host;
            end
            st_q <= ST_RESP;
          end
        end
        ST_RESP: if (resp_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (st_q == ST_IDLE);
  assign mem_req_valid = (st_q == ST_RD_DIR) || (st_q == ST_RD_LEAF);
  assign mem_rsp_ready = (st_q == ST_WT_DIR) || (st_q == ST_WT_LEAF);
  assign sel_leaf      = (st_q == ST_RD_LEAF);
  assign resp_valid    = (st_q == ST_RESP);
  assign resp_fault    = fault_q;
  assign resp_cause    = cause_q;
  assign resp_hofs     = host_q;

endmodule

// File: rtl/mtt_walker.sv
module mtt_walker
  import walk_pkg::*;
#(
  parameter int HAW    = 37,
  parameter int OFS_W  = 48,
  parameter int FN_W   = 8,
  parameter int NUM_FN = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [HAW-1:0]   root_base,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [FN_W-1:0]  req_fn,
  input  logic [OFS_W-1:0] req_ofs,
  output logic             resp_valid,
  input  logic             resp_ready,
  output logic             resp_fault,
  output logic [1:0]       resp_cause,
  output logic [HAW-1:0]   resp_hofs,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [HAW-1:0]   mem_req_addr,
  input  logic             mem_rsp_valid,
  output logic             mem_rsp_ready,
  input  logic [ENT_W-1:0] mem_rsp_data
);

  localparam int PTR_W = HAW - TBL_SHIFT;

  logic             req_bad;
  logic             sel_leaf;
  logic             ent_valid;
  logic [PTR_W-1:0] ent_ptr;
  logic [PTR_W-1:0] ptr_q;
  logic [HAW-1:0]   ent_host;
  logic [HAW-1:0]   dir_addr;
  logic [HAW-1:0]   leaf_addr;
  logic [FN_W-1:0]  fn_q;
  logic [HAW-1:0]   ofs_q;

  walk_reqcheck #(.HAW(HAW), .OFS_W(OFS_W), .FN_W(FN_W), .NUM_FN(NUM_FN)) u_chk_req (
    .fn  (req_fn),
    .ofs (req_ofs),
    .bad (req_bad)
  );

  walk_addrgen #(.HAW(HAW), .FN_W(FN_W)) u_agen (
    .root      (root_base),
    .fn        (fn_q),
    .ofs       (ofs_q),
    .ptr       (ptr_q),
    .ent       (mem_rsp_data),
    .dir_addr  (dir_addr),
    .leaf_addr (leaf_addr),
    .ent_valid (ent_valid),
    .ent_ptr   (ent_ptr),
    .ent_host  (ent_host)
  );

  walk_fsm #(.HAW(HAW), .OFS_W(OFS_W), .FN_W(FN_W)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_fn        (req_fn),
    .req_ofs       (req_ofs),
    .req_bad       (req_bad),
    .req_ready     (req_ready),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_req_valid (mem_req_valid),
    .mem_rsp_ready (mem_rsp_ready),
    .sel_leaf      (sel_leaf),
    .ent_valid     (ent_valid),
    .ent_ptr       (ent_ptr),
    .ent_host      (ent_host),
    .fn_q          (fn_q),
    .ofs_q         (ofs_q),
    .ptr_q         (ptr_q),
    .resp_ready    (resp_ready),
    .resp_valid    (resp_valid),
    .resp_fault    (resp_fault),
    .resp_cause    (resp_cause),
    .resp_hofs     (resp_hofs)
  );

  assign mem_req_addr = sel_leaf ? leaf_addr : dir_addr;

endmodule

// File: rtl/mtt_walker_chk.sv
module mtt_walker_chk #(
  parameter int HAW    = 37,
  parameter int OFS_W  = 48,
  parameter int FN_W   = 8,
  parameter int NUM_FN = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [FN_W-1:0]  req_fn,
  input logic [OFS_W-1:0] req_ofs,
  input logic             resp_valid,
  input logic             resp_ready,
  input logic             resp_fault,
  input logic [1:0]       resp_cause,
  input logic [HAW-1:0]   resp_hofs,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [HAW-1:0]   mem_req_addr,
  input logic             mem_rsp_ready
);

  logic take_bad;
  assign take_bad = req_valid && req_ready &&
                    ((req_fn == '0) || (32'(req_fn) >= NUM_FN) ||
                     ((req_ofs >> HAW) != '0));

  assert_bad_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take_bad |=> resp_valid && resp_fault && (resp_cause == 2'd1) && !mem_req_valid);

  assert_ok_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_fault |-> resp_cause == 2'd0);

  assert_fault_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_fault |-> resp_hofs == '0 && resp_cause != 2'd0);

  assert_single_walk_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  assert_busy_resp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !req_ready);

  assert_resp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_fault) &&
                                  $stable(resp_cause) && $stable(resp_hofs));

  assert_mreq_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  assert_one_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req_valid && mem_rsp_ready));

endmodule

bind mtt_walker mtt_walker_chk #(.HAW(HAW), .OFS_W(OFS_W), .FN_W(FN_W), .NUM_FN(NUM_FN)) u_walk_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_fn        (req_fn),
  .req_ofs       (req_ofs),
  .resp_valid    (resp_valid),
  .resp_ready    (resp_ready),
  .resp_fault    (resp_fault),
  .resp_cause    (resp_cause),
  .resp_hofs     (resp_hofs),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_ready (mem_rsp_ready)
);

// File: tb/sim_mtt_walker.sv
module sim_mtt_walker;

  localparam int CLK_PERIOD = 10;
  localparam int HAW   = 37;
  localparam int OFS_W = 48;
  localparam logic [HAW-1:0] ROOT = 37'h00_1000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [7:0] req_fn = '0;
  logic [OFS_W-1:0] req_ofs = '0;
  logic resp_valid, resp_ready = 1'b0, resp_fault;
  logic [1:0] resp_cause;
  logic [HAW-1:0] resp_hofs;
  logic mem_req_valid, mem_req_ready = 1'b0, mem_rsp_valid = 1'b0, mem_rsp_ready;
  logic [HAW-1:0] mem_req_addr;
  logic [31:0] mem_rsp_data = '0;

  int checks = 0;
  int fails = 0;
  logic [31:0] mem [logic [HAW-1:0]];
  logic [HAW-1:0] rd_addr [4];
  int rd_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mtt_walker u0 (
    .clk(clk), .rst_n(rst_n), .root_base(ROOT),
    .req_valid(req_valid), .req_ready(req_ready), .req_fn(req_fn), .req_ofs(req_ofs),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_fault(resp_fault),
    .resp_cause(resp_cause), .resp_hofs(resp_hofs),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] memval(input logic [HAW-1:0] a);
    if (mem.exists(a)) return mem[a];
    return a[31:0] * 32'h9E37_79B1 ^ 32'h2545_F491;
  endfunction

  function automatic void model(input logic [7:0] fn, input logic [OFS_W-1:0] ofs,
                                output bit f, output logic [1:0] c, output logic [HAW-1:0] h,
                                output int nr, output logic [HAW-1:0] da, output logic [HAW-1:0] la);
    logic [31:0] pde, pte;
    da = ROOT + HAW'(fn) * 4;
    la = '0; h = '0;
    if (fn == 0 || fn >= 64 || ofs[OFS_W-1:HAW] != '0) begin
      f = 1; c = 2'd1; nr = 0; return;
    end
    pde = memval(da);
    if (!pde[0]) begin f = 1; c = 2'd2; nr = 1; return; end
    la = {pde[24:4], 16'h0} + HAW'({ofs[36:21], 2'b00});
    pte = memval(la);
    nr = 2;
    if (!pte[0]) begin f = 1; c = 2'd3; return; end
    f = 0; c = 2'd0; h = {pte[20:5], ofs[20:0]};
  endfunction

  // memory responder, single outstanding read, random latency
  initial begin
    bit req_fire = 0, rsp_fire = 0, pend = 0, stall = 0;
    int dly = 0;
    logic [HAW-1:0] pa = '0, stall_addr = '0;
    forever begin
      @(negedge clk);
      if (!rst_n) continue;
      if (rsp_fire) begin mem_rsp_valid = 1'b0; rsp_fire = 0; end
      if (stall) begin
        chk(mem_req_valid && mem_req_addr == stall_addr, "R10", "req held",
            longint'(mem_req_addr), longint'(stall_addr));
        stall = 0;
      end
      if (req_fire) begin
        if (rd_n < 4) rd_addr[rd_n] = pa;
        rd_n++;
        pend = 1; dly = int'($urandom % 3); req_fire = 0;
      end
      if (pend && !mem_rsp_valid) begin
        if (dly == 0) begin
          mem_rsp_valid = 1'b1; mem_rsp_data = memval(pa); pend = 0;
        end else dly--;
      end
      if (mem_req_valid && (pend || mem_rsp_valid))
        chk(0, "R10", "request while read outstanding", 1, 0);
      mem_req_ready = ($urandom % 3) != 0;
      if (mem_req_valid && mem_req_ready) begin req_fire = 1; pa = mem_req_addr; end
      if (mem_req_valid && !mem_req_ready) begin stall = 1; stall_addr = mem_req_addr; end
      if (mem_rsp_valid && mem_rsp_ready) rsp_fire = 1;
    end
  end

  task automatic walk(input logic [7:0] fn, input logic [OFS_W-1:0] ofs, input int hold,
                      input string tag);
    bit f; logic [1:0] c; logic [HAW-1:0] h, da, la; int nr;
    logic af; logic [1:0] ac; logic [HAW-1:0] ah;
    model(fn, ofs, f, c, h, nr, da, la);
    rd_n = 0;
    req_fn = fn; req_ofs = ofs; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R8", "ready low after accept", longint'(req_ready), 0);
    while (!resp_valid) @(negedge clk);
    af = resp_fault; ac = resp_cause; ah = resp_hofs;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(resp_valid && resp_fault == af && resp_cause == ac && resp_hofs == ah,
          "R9", "response held", longint'(resp_hofs), longint'(ah));
      chk(!req_ready, "R8", "ready low while responding", longint'(req_ready), 0);
    end
    resp_ready = 1'b1;
    @(negedge clk);
    resp_ready = 1'b0;
    chk(af == f, tag, "fault", longint'(af), longint'(f));
    chk(ac == c, tag, "cause", longint'(ac), longint'(c));
    chk(ah == h, tag, "host offset", longint'(ah), longint'(h));
    chk(rd_n == nr, tag, "read count", rd_n, nr);
    if (nr >= 1) chk(rd_addr[0] == da, "R2", "directory addr", longint'(rd_addr[0]), longint'(da));
    if (nr >= 2) chk(rd_addr[1] == la, "R5", "leaf addr", longint'(rd_addr[1]), longint'(la));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) begin
      logic [31:0] w = $urandom;
      if (($urandom % 4) == 0) w[0] = 1'b0;
      mem[ROOT + HAW'(i) * 4] = w;
    end
    // fn 5: invalid directory entry with pointer bits set
    mem[ROOT + 37'd20] = 32'hFFFF_FFFE;
    // fn 7: valid, reserved bits set, pointer 0x12345
    mem[ROOT + 37'd28] = 32'hFE00_000F | (32'h12345 << 4);
    mem[{21'h12345, 16'h0}]                 = 32'hFFE0_001F | (32'hABCD << 5);
    mem[{21'h12345, 16'h0} + 37'h3FFFC]     = 32'h0000_0001 | (32'h1357 << 5);
    mem[{21'h12345, 16'h0} + 37'd4]         = 32'hFFFF_FFFE;

    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "req_ready after reset", longint'(req_ready), 1);
    chk(resp_valid == 1'b0, "R1", "resp_valid after reset", longint'(resp_valid), 0);
    chk(mem_req_valid == 1'b0, "R1", "mem_req_valid after reset", longint'(mem_req_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    walk(8'd0,   48'h0000_0020_0000, 0, "R3");
    walk(8'd64,  48'h0000_0020_0000, 2, "R3");
    walk(8'd200, 48'h0, 0, "R3");
    walk(8'd7,   48'h0020_0000_0000, 1, "R3");
    walk(8'd5,   48'h0000_0000_1234, 0, "R4");
    walk(8'd7,   48'h0000_0001_2345, 3, "R11");
    walk(8'd7,   48'h001F_FFFF_FFFF, 0, "R5");
    walk(8'd7,   48'h0000_0020_0042, 1, "R6");
    walk(8'd7,   48'h0000_001F_FFFF, 0, "R7");

    for (int n = 0; n < 400; n++) begin
      logic [7:0] fn;
      logic [OFS_W-1:0] ofs;
      fn = (($urandom % 8) == 0) ? 8'($urandom) : 8'($urandom % 64);
      ofs = {$urandom, $urandom} & 48'h001F_FFFF_FFFF;
      if (($urandom % 10) == 0) ofs[37 + ($urandom % 11)] = 1'b1;
      walk(fn, ofs, int'($urandom % 3), "R7");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule